// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Lock Monitor

This block is the digital core of a phase-locked frequency synthesizer. It runs on one system clock, and two single-cycle enables stand in for the edges of the crystal and of the prescaled oscillator. A reference divider turns crystal edges into reference ticks at a rate picked by a 4-bit select. A feedback divider turns oscillator edges into feedback ticks. A three-state phase comparator turns the two tick streams into up and down pump requests.

The meaning of the 16-bit divide word depends on two mode bits:
- **High band:** the modulus is twice the word.
- **Sense:** the modulus is the word itself.
- **Coarse (both bits clear):** only the upper twelve bits count.

Two select codes halt the loop. One of them also drops the oscillator run enable.

A lock monitor watches the width of the phase-error pulse. It can stretch long errors into an unlock flag, pass the raw error through, or be switched off. It keeps a sticky lock status that is cleared by an unlock and rearmed by a read strobe. A force-down input pins the pump to its down state, which lets the loop recover from a stalled oscillator.

Top module: `pll_synth_core`

## Requirements
- R1: With `refSel` codes 0x0–0x3 the reference divisor is 3. The other divisors are: 0x4 gives 6, 0x5 gives 12, 0x6 and 0x7 give 24, 0x8–0xA give 15, 0xB gives 75, 0xC gives 25 and 0xD gives 5. Each of these is a 75 kHz crystal divided down to the chosen rate. `refTick` pulses for one cycle, one cycle after every D-th `xtalEn` pulse.
- R2: With `highBand`=1, `fbTick` pulses once every 2×`divWord` `fbEn` pulses, whatever the value of `sense`.
- R3: With `highBand`=0 and `sense`=1, `fbTick` pulses once every `divWord` `fbEn` pulses.
- R4: With `highBand`=0 and `sense`=0, `fbTick` pulses once every `divWord[15:4]` `fbEn` pulses, and `divWord[3:0]` has no effect on the period.
- R5: `refSel`=0xF or 0xE halts the loop. While halted:
  - no `refTick` or `fbTick` is produced;
  - `pumpUp`, `pumpDown` and `pumpEnable` are 0;
  - both dividers restart from zero when the halt ends.
  
  `oscRun` is 0 only for code 0xE.
- R6: `pumpUp` rises the cycle after a reference tick, and `pumpDown` rises the cycle after a feedback tick. Once both edges have arrived, both clear. The pump request therefore lasts exactly as many cycles as the two ticks are apart, and `pumpUp` and `pumpDown` are never both high.
- R7: While `forceDown`=1 and the loop is not halted, `pumpDown`=1 and `pumpUp`=0. When the loop is halted, the halt wins.
- R8: With `unlockSel[1]`=1, a phase-error pulse longer than ERR_WINDOW cycles drives `unlockOut` high. It stays high until STRETCH_CYC cycles after the last over-window cycle. A pulse of ERR_WINDOW cycles or less leaves `unlockOut` low.
- R9: With `unlockSel`=01, `unlockOut` equals the phase error, which is `pumpUp` or `pumpDown` before the force-down override.
- R10: With `unlockSel`=00, `unlockOut` is 0 and `lockStatus` is 1.
- R11: `lockStatus` falls the cycle after `unlockOut` is high. It stays 0 until a `statusRead` pulse in a cycle with `unlockOut` low, which sets it back to 1 from the next cycle.
- R12: After reset `refTick`, `fbTick`, `pumpUp`, `pumpDown` and `unlockOut` are 0, and `lockStatus` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalEn | input | 1 | One-cycle pulse per crystal edge |
| fbEn | input | 1 | One-cycle pulse per prescaled oscillator edge |
| divWord | input | 16 | Feedback divide word |
| highBand | input | 1 | Doubled-count mode |
| sense | input | 1 | Full-resolution mode when highBand is 0 |
| refSel | input | 4 | Reference rate select; 0xE and 0xF halt |
| unlockSel | input | 2 | Unlock detector mode |
| forceDown | input | 1 | Pin the pump to its down state |
| statusRead | input | 1 | Read strobe that rearms lockStatus |
| refTick | output | 1 | Reference divider tick |
| fbTick | output | 1 | Feedback divider tick |
| pumpUp | output | 1 | Pump up request |
| pumpDown | output | 1 | Pump down request |
| pumpEnable | output | 1 | Pump driven (0 = released) |
| oscRun | output | 1 | Oscillator run enable |
| unlockOut | output | 1 | Unlock detector output |
| lockStatus | output | 1 | Sticky lock status |

## Verification
The bench places the two final divider edges a chosen number of cycles apart. This makes pulses of exactly ERR_WINDOW and ERR_WINDOW+1 cycles, with the reference leading and with the feedback leading. An off-by-one window would flag the shorter pulse or miss the longer one, and a wrong reload would shorten the stretch. Divider periods are measured over two full wraps, in every mode and across the whole reference code table. This catches:
- a modulus that is off by one;
- a coarse mode that lets the low nibble leak into the count;
- a double count applied in the wrong mode.

The halt codes are driven with both enables active, and then a period is measured. A design that keeps counting or leaves the pump driven would show stray ticks or a shifted first period.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

  localparam int DIV_W   = 16;
  localparam int FB_W    = DIV_W + 1;
  localparam int REF_W   = 7;
  localparam int SEL_W   = 4;
  localparam int XTAL_HZ = 75000;

  localparam logic [SEL_W-1:0] SEL_HALT     = 4'hF;
  localparam logic [SEL_W-1:0] SEL_HALT_OSC = 4'hE;

  // control-to-datapath strobes and limits
  typedef struct packed {
    logic             inhibit;
    logic             forceDown;
    logic [REF_W-1:0] refLast;
    logic [FB_W-1:0]  fbLast;
  } pllCmd_t;

  function automatic logic [REF_W-1:0] refDivisor(input logic [SEL_W-1:0] sel);
    int rateHz;
    case (sel)
      4'h0, 4'h1, 4'h2, 4'h3: rateHz = 25000;
      4'h4:                   rateHz = 12500;
      4'h5:                   rateHz = 6250;
      4'h6, 4'h7:             rateHz = 3125;
      4'h8, 4'h9, 4'hA:       rateHz = 5000;
      4'hB:                   rateHz = 1000;
      4'hC:                   rateHz = 3000;
      4'hD:                   rateHz = 15000;
      default:                rateHz = XTAL_HZ;
    endcase
    return REF_W'(XTAL_HZ / rateHz);
  endfunction

  function automatic logic [FB_W-1:0] fbModulus(input logic [DIV_W-1:0] word,
                                                input logic hb, input logic sns);
    if (hb)       return {word, 1'b0};
    else if (sns) return {1'b0, word};
    else          return FB_W'(word[DIV_W-1:4]);
  endfunction

endpackage

// File: rtl/pll_core_ctrl.sv
module pll_core_ctrl
  import pll_core_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divWord,
  input  logic             highBand,
  input  logic             sense,
  input  logic [SEL_W-1:0] refSel,
  input  logic             forceDown,
  output pllCmd_t          cmd,
  output logic             oscRun
);

  logic [FB_W-1:0]  modulus;
  logic [REF_W-1:0] refDiv;
  logic             halt;

  always_comb begin
    modulus = fbModulus(divWord, highBand, sense);
    refDiv  = refDivisor(refSel);
    halt    = (refSel == SEL_HALT) || (refSel == SEL_HALT_OSC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd.inhibit   <= 1'b1;
      cmd.forceDown <= 1'b0;
      cmd.refLast   <= '0;
      cmd.fbLast    <= '0;
      oscRun        <= 1'b1;
    end else begin
      cmd.inhibit   <= halt;
      cmd.forceDown <= forceDown;
      cmd.refLast   <= refDiv - 1'b1;
      cmd.fbLast    <= (modulus == '0) ? '0 : modulus - 1'b1;
      oscRun        <= (refSel != SEL_HALT_OSC);
    end
  end

  AST_OSC_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(refSel) == SEL_HALT_OSC) |-> (!oscRun && cmd.inhibit)); // R5

endmodule

// File: rtl/pll_core_tickdiv.sv
module pll_core_tickdiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         tick
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        if (cnt >= last) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(step)); // R1 R2 R3 R4

endmodule

// File: rtl/pll_core_datapath.sv
module pll_core_datapath
  import pll_core_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  pllCmd_t cmd,
  input  logic    xtalEn,
  input  logic    fbEn,
  output logic    refTick,
  output logic    fbTick,
  output logic    pumpUp,
  output logic    pumpDown,
  output logic    pumpEnable,
  output logic    phaseErr
);

  localparam int N_DIV = 2;

  logic [N_DIV-1:0] stepVec;
  logic [N_DIV-1:0] tickVec;
  logic             upQ, dnQ, upNext, dnNext;

  assign stepVec = {fbEn, xtalEn};

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    if (g == 0) begin : g_ref
      pll_core_tickdiv #(.W(REF_W)) u_div (
        .clk(clk), .rstN(rstN), .clear(cmd.inhibit), .step(stepVec[g]),
        .last(cmd.refLast), .tick(tickVec[g]));
    end else begin : g_fb
      pll_core_tickdiv #(.W(FB_W)) u_div (
        .clk(clk), .rstN(rstN), .clear(cmd.inhibit), .step(stepVec[g]),
        .last(cmd.fbLast), .tick(tickVec[g]));
    end
  end

  assign refTick = tickVec[0];
  assign fbTick  = tickVec[1];

  // three-state comparator: both requests clear once both edges are in
  always_comb begin
    upNext = upQ | refTick;
    dnNext = dnQ | fbTick;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.inhibit) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end

  assign phaseErr   = upQ | dnQ;
  assign pumpEnable = !cmd.inhibit;
  assign pumpUp     = !cmd.inhibit && !cmd.forceDown && upQ;
  assign pumpDown   = !cmd.inhibit && (cmd.forceDown || dnQ);

  AST_PD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(upQ && dnQ)); // R6
  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && fbTick) |=> (!upQ && !dnQ)); // R6
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inhibit |=> (!refTick && !fbTick && !upQ && !dnQ)); // R5

endmodule

// File: rtl/pll_core_lockdet.sv
module pll_core_lockdet #(
  parameter int ERR_WINDOW  = 8,
  parameter int STRETCH_CYC = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseErr,
  input  logic [1:0] detMode,
  input  logic       statusRead,
  output logic       unlockOut,
  output logic       lockStatus
);

  localparam int RUN_W = $clog2(ERR_WINDOW + 1);
  localparam int STR_W = $clog2(STRETCH_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ERR_WINDOW);
  localparam logic [STR_W-1:0] STR_MAX = STR_W'(STRETCH_CYC);

  logic [RUN_W-1:0] errRun;
  logic [STR_W-1:0] stretchCnt;
  logic             stickyQ;
  logic             overWindow;

  assign overWindow = phaseErr && (errRun == RUN_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errRun     <= '0;
      stretchCnt <= '0;
    end else begin
      if (!phaseErr)              errRun <= '0;
      else if (errRun != RUN_MAX) errRun <= errRun + 1'b1;

      if (!detMode[1])            stretchCnt <= '0;
      else if (overWindow)        stretchCnt <= STR_MAX;
      else if (stretchCnt != '0)  stretchCnt <= stretchCnt - 1'b1;
    end
  end

  always_comb begin
    case (detMode)
      2'b00:   unlockOut = 1'b0;
      2'b01:   unlockOut = phaseErr;
      default: unlockOut = (stretchCnt != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  stickyQ <= 1'b1;
    else if (detMode == 2'b00)  stickyQ <= 1'b1;
    else if (unlockOut)         stickyQ <= 1'b0;
    else if (statusRead)        stickyQ <= 1'b1;
  end

  assign lockStatus = stickyQ || (detMode == 2'b00);

  AST_STOPPED_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(detMode) == 2'b00) |-> stickyQ); // R10
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (unlockOut && detMode != 2'b00) |=> !stickyQ); // R11
  AST_SHORT_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (detMode[1] && $past(detMode[1]) && !phaseErr && !$past(phaseErr) && stretchCnt == '0)
      |=> !unlockOut); // R8

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_core_pkg::*;
#(
  parameter int ERR_WINDOW  = 8,
  parameter int STRETCH_CYC = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xtalEn,
  input  logic        fbEn,
  input  logic [15:0] divWord,
  input  logic        highBand,
  input  logic        sense,
  input  logic [3:0]  refSel,
  input  logic [1:0]  unlockSel,
  input  logic        forceDown,
  input  logic        statusRead,
  output logic        refTick,
  output logic        fbTick,
  output logic        pumpUp,
  output logic        pumpDown,
  output logic        pumpEnable,
  output logic        oscRun,
  output logic        unlockOut,
  output logic        lockStatus
);

  pllCmd_t cmd;
  logic    phaseErr;

  pll_core_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .divWord(divWord), .highBand(highBand),
    .sense(sense), .refSel(refSel), .forceDown(forceDown),
    .cmd(cmd), .oscRun(oscRun));

  pll_core_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .xtalEn(xtalEn), .fbEn(fbEn),
    .refTick(refTick), .fbTick(fbTick), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpEnable(pumpEnable), .phaseErr(phaseErr));

  pll_core_lockdet #(.ERR_WINDOW(ERR_WINDOW), .STRETCH_CYC(STRETCH_CYC)) u_lock (
    .clk(clk), .rstN(rstN), .phaseErr(phaseErr), .detMode(unlockSel),
    .statusRead(statusRead), .unlockOut(unlockOut), .lockStatus(lockStatus));

endmodule

// File: tb/pll_synth_core_bench.sv
`timescale 1ns/1ps
module pll_synth_core_bench;

  localparam int W = 8;
  localparam int S = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xtalEn = 1'b0, fbEn = 1'b0, highBand = 1'b0, sense = 1'b1;
  logic forceDown = 1'b0, statusRead = 1'b0;
  logic [15:0] divWord = 16'd3;
  logic [3:0]  refSel = 4'h0;
  logic [1:0]  unlockSel = 2'b00;
  logic refTick, fbTick, pumpUp, pumpDown, pumpEnable, oscRun, unlockOut, lockStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pll_synth_core #(.ERR_WINDOW(W), .STRETCH_CYC(S)) u_pll_synth_core (
    .clk(clk), .rstN(rstN), .xtalEn(xtalEn), .fbEn(fbEn), .divWord(divWord),
    .highBand(highBand), .sense(sense), .refSel(refSel), .unlockSel(unlockSel),
    .forceDown(forceDown), .statusRead(statusRead), .refTick(refTick),
    .fbTick(fbTick), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpEnable(pumpEnable), .oscRun(oscRun), .unlockOut(unlockOut),
    .lockStatus(lockStatus));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRefDiv(input logic [3:0] code);
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3: return 3;
      4'h4: return 6;
      4'h5: return 12;
      4'h6, 4'h7: return 24;
      4'h8, 4'h9, 4'hA: return 15;
      4'hB: return 75;
      4'hC: return 25;
      default: return 5;
    endcase
  endfunction

  function automatic int expFbMod(input logic [15:0] w, input logic hb, input logic sn);
    if (hb) return 2 * int'(w);
    if (sn) return int'(w);
    return int'(w[15:4]);
  endfunction

  function automatic int expUnlock(input int k, input logic [1:0] mode);
    if (mode == 2'b00) return 0;
    if (mode == 2'b01) return k;
    return (k > W) ? (k - W - 1 + S) : 0;
  endfunction

  task automatic restart(input logic [3:0] code);
    @(negedge clk);
    xtalEn = 1'b0; fbEn = 1'b0; refSel = 4'hF;
    repeat (2) @(negedge clk);
    refSel = code;
    repeat (2) @(negedge clk);
  endtask

  // R1: two reference periods with xtalEn held high
  task automatic measureRef(input logic [3:0] code);
    int first = 0, second = 0, d = expRefDiv(code);
    restart(code);
    xtalEn = 1'b1;
    for (int c = 1; c <= 2 * d + 5; c++) begin
      @(negedge clk);
      if (refTick) begin
        if (first == 0) first = c;
        else if (second == 0) second = c;
      end
    end
    xtalEn = 1'b0;
    chk(first == d, "R1 first ref period", first, d);
    chk(second - first == d, "R1 ref wrap period", second - first, d);
  endtask

  task automatic measureFb(input logic [15:0] w, input logic hb, input logic sn,
                           input string req);
    int first = 0, second = 0, n = expFbMod(w, hb, sn);
    divWord = w; highBand = hb; sense = sn; unlockSel = 2'b00;
    restart(4'h0);
    fbEn = 1'b1;
    for (int c = 1; c <= 2 * n + 5; c++) begin
      @(negedge clk);
      if (fbTick) begin
        if (first == 0) first = c;
        else if (second == 0) second = c;
      end
    end
    fbEn = 1'b0;
    chk(first == n, req, first, n);
    chk(second - first == n, req, second - first, n);
  endtask

  // final edges k cycles apart; the leading side wins by k cycles
  task automatic phaseGap(input int k, input bit fbLead, input logic [1:0] mode);
    int leadCnt = 0, lagCnt = 0, unlCnt = 0, expU;
    bit leadOn, lagOn;
    divWord = 16'd3; highBand = 1'b0; sense = 1'b1; unlockSel = mode;
    restart(4'h0);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    xtalEn = 1'b1; fbEn = 1'b1;
    for (int c = 1; c <= k + 8 + S; c++) begin
      @(negedge clk);
      if (fbLead ? pumpDown : pumpUp) leadCnt++;
      if (fbLead ? pumpUp : pumpDown) lagCnt++;
      if (unlockOut) unlCnt++;
      leadOn = (c + 1) <= 3;
      lagOn  = ((c + 1) <= 2) || ((c + 1) == 3 + k);
      xtalEn = fbLead ? lagOn : leadOn;
      fbEn   = fbLead ? leadOn : lagOn;
    end
    xtalEn = 1'b0; fbEn = 1'b0;
    expU = expUnlock(k, mode);
    chk(leadCnt == k, "R6 lead request width", leadCnt, k);
    chk(lagCnt == 0, "R6 lag request stays low", lagCnt, 0);
    chk(unlCnt == expU, (mode == 2'b00) ? "R10 unlockOut cycles" :
        (mode == 2'b01) ? "R9 unlockOut cycles" : "R8 unlockOut cycles", unlCnt, expU);
    chk(lockStatus == ((mode == 2'b00) || expU == 0), "R11 lockStatus after error",
        lockStatus, (mode == 2'b00) || expU == 0);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chk(lockStatus == 1'b1, "R11 lockStatus rearmed by read", lockStatus, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!refTick && !fbTick, "R12 ticks low", refTick + fbTick, 0);
    chk(!pumpUp && !pumpDown, "R12 pump low", pumpUp + pumpDown, 0);
    chk(!unlockOut && lockStatus, "R12 lock state", {unlockOut, lockStatus}, 1);

    // R1 full code table
    for (int code = 0; code < 14; code++) measureRef(4'(code));

    // R2, R3, R4 directed corners
    measureFb(16'd272, 1'b1, 1'b0, "R2 high band 272");
    measureFb(16'd5, 1'b1, 1'b1, "R2 high band ignores sense");
    measureFb(16'd272, 1'b0, 1'b1, "R3 sense 272");
    measureFb(16'h0040, 1'b0, 1'b0, "R4 coarse nibble 0");
    measureFb(16'h004F, 1'b0, 1'b0, "R4 coarse nibble F");
    // randomized modes and words
    for (int i = 0; i < 9; i++) begin
      int m = $urandom_range(0, 2);
      if (m == 0) measureFb(16'($urandom_range(2, 200)), 1'b1, 1'($urandom_range(0, 1)), "R2 random");
      else if (m == 1) measureFb(16'($urandom_range(2, 400)), 1'b0, 1'b1, "R3 random");
      else measureFb({4'h0, 8'($urandom_range(1, 63)), 4'($urandom_range(0, 15))}, 1'b0, 1'b0, "R4 random");
    end

    // R5 halt codes
    for (int h = 0; h < 2; h++) begin
      int stray = 0;
      logic [3:0] code = (h == 0) ? 4'hF : 4'hE;
      @(negedge clk);
      refSel = code; xtalEn = 1'b1; fbEn = 1'b1;
      repeat (2) @(negedge clk);
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (refTick || fbTick || pumpUp || pumpDown || pumpEnable) stray++;
      end
      chk(stray == 0, "R5 halted outputs quiet", stray, 0);
      chk(oscRun == (code != 4'hE), "R5 oscRun per halt code", oscRun, code != 4'hE);
      xtalEn = 1'b0; fbEn = 1'b0;
    end
    measureRef(4'h4); // R1 after halt: dividers restart clean

    // R7 force down
    restart(4'h0);
    forceDown = 1'b1;
    repeat (2) @(negedge clk);
    chk(pumpDown && !pumpUp && pumpEnable, "R7 forced down", {pumpUp, pumpDown, pumpEnable}, 3'b011);
    refSel = 4'hF;
    repeat (2) @(negedge clk);
    chk(!pumpDown && !pumpEnable, "R7 halt beats force", {pumpDown, pumpEnable}, 0);
    forceDown = 1'b0;

    // R6, R8, R9, R10, R11 directed window edges
    phaseGap(W, 1'b0, 2'b10);
    phaseGap(W + 1, 1'b0, 2'b10);
    phaseGap(W + 1, 1'b1, 2'b11);
    phaseGap(2, 1'b1, 2'b01);
    phaseGap(15, 1'b0, 2'b00);
    for (int i = 0; i < 12; i++)
      phaseGap($urandom_range(1, 20), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule